// File: doc/BRIEF.md
# Decimal Accumulator Processor

This block is a small multicycle processor that runs programs written as three-digit decimal words. Each word holds three BCD digits. The top digit chooses the operation and the lower two digits give a memory address from 00 to 99. One memory of 100 words holds both code and data. Every instruction passes through separate phases, and each phase moves data between explicit registers: the program counter, the memory address register, the memory data register, the current instruction register and the accumulator.

A program is placed in memory through a load port, and this port only works while reset is held. When reset is released, execution starts at address 00. Values come in on a valid/ready stream. The core raises `in_ready` only while an input instruction waits, and it moves on only after a beat is accepted. Results go out on a second valid/ready stream. The core keeps `out_valid` high with the accumulator on `out_data` until the consumer asserts `out_ready`, so a slow consumer stalls the core without losing a value. A one-cycle `irq_req` pulse is remembered. When the current instruction finishes, the core writes the return address into a fixed save word and then jumps to a fixed service address.

Top module: `deca_core`

## Requirements
- R1: While `rst` is high, `halted`, `out_valid` and `in_ready` are low. After `rst` falls, the first instruction is fetched from address 00.
- R2: While `rst` is high, a cycle with `ld_en` high writes `ld_data` to the BCD address `ld_addr`. While `rst` is low, `ld_en` has no effect on memory.
- R3: A word is three BCD digits in bits [11:8], [7:4] and [3:0]. Bits [11:8] are the opcode: 0 halt, 1 add, 2 subtract, 3 store, 5 load, 6 jump, 7 jump-if-zero, 8 jump-if-not-negative, 9 I/O. Bits [7:0] are a two-digit BCD operand.
- R4: Add and subtract combine the accumulator with the memory word at the operand address, modulo 1000. A subtract whose true result is below zero sets the negative flag. A subtract whose result is not negative clears it, and so do load, add and input.
- R5: Load copies the word at the operand address into the accumulator. Store writes the accumulator to the operand address.
- R6: Jump always loads PC from the operand. Jump-if-zero loads PC only when the accumulator is 000. Jump-if-not-negative loads PC only when the negative flag is clear, and this includes an accumulator of 000.
- R7: Word 901 is input. `in_ready` stays high until a cycle with `in_valid` high. In that cycle `in_data` is taken into the accumulator.
- R8: Word 902 is output. `out_valid` rises with `out_data` equal to the accumulator. Both stay unchanged until a cycle with `out_ready` high, which completes the beat.
- R9: An opcode-0 word raises `halted`. `halted` then stays high until reset, and no further input or output beats occur.
- R10: Opcode 4, and opcode 9 with an operand other than 01 or 02, change nothing except PC.
- R11: PC counts in BCD, and a fetch from address 99 is followed by a fetch from address 00.
- R12: A pulse on `irq_req` sets a pending bit. When the current instruction ends with that bit set, the core writes the return address (with a 0 hundreds digit) to word 99, loads PC with 90 and clears the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; enables the load port |
| ld_en | input | 1 | Load strobe, honoured only in reset |
| ld_addr | input | 8 | Two-digit BCD load address |
| ld_data | input | 12 | Word to load |
| irq_req | input | 1 | Interrupt request pulse |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Core waits for an input beat |
| in_data | input | 12 | Input value, three BCD digits |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts output beat |
| out_data | output | 12 | Output value, three BCD digits |
| halted | output | 1 | Halt reached, held until reset |

## Verification
Random operand pairs are fed through an input-add/subtract-output-branch program, with the input and output streams stalled at random. This separates a correct BCD carry and borrow chain from one that only works on small numbers, and it shows whether the negative flag steers the branch. Directed operand pairs cover cases that random values rarely hit: equal operands (a zero result must still branch), a subtract that wraps to 999, and an add that wraps to 000. Short directed programs cover the remaining points: a jump that wraps PC from 99 to 00, both kinds of no-operation, store followed by load, a load-port write attempted while the core runs, a flag cleared by an add, and an interrupt raised during an input stall.

// File: rtl/deca_pkg.sv
`timescale 1ns/1ps
package deca_pkg;
  localparam int DIG_W       = 4;
  localparam int WORD_DIGITS = 3;
  localparam int ADDR_DIGITS = 2;
  localparam int WORD_W      = DIG_W * WORD_DIGITS;
  localparam int ADDR_W      = DIG_W * ADDR_DIGITS;
  localparam int MEM_WORDS   = 100;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DIG_W-1:0]  digit_t;

  typedef enum logic [3:0] {
    ST_FA, ST_FB, ST_FC, ST_DEC, ST_EXEC, ST_ALU, ST_IN, ST_OUT, ST_CHK, ST_HALT
  } phase_e;

  localparam digit_t OP_HLT = 4'd0;
  localparam digit_t OP_ADD = 4'd1;
  localparam digit_t OP_SUB = 4'd2;
  localparam digit_t OP_STA = 4'd3;
  localparam digit_t OP_LDA = 4'd5;
  localparam digit_t OP_BRA = 4'd6;
  localparam digit_t OP_BRZ = 4'd7;
  localparam digit_t OP_BRP = 4'd8;
  localparam digit_t OP_IO  = 4'd9;

  localparam addr_t IO_IN  = 8'h01;
  localparam addr_t IO_OUT = 8'h02;

  // decimal value of a BCD address
  function automatic int addr_index(input addr_t a);
    int idx;
    idx = 0;
    for (int i = ADDR_DIGITS - 1; i >= 0; i--)
      idx = idx * 10 + int'(a[i*DIG_W +: DIG_W]);
    return idx;
  endfunction

  // BCD increment; the all-nines address rolls over to zero
  function automatic addr_t addr_next(input addr_t a);
    addr_t r;
    logic  cy;
    r  = a;
    cy = 1'b1;
    for (int i = 0; i < ADDR_DIGITS; i++) begin
      if (cy) begin
        if (r[i*DIG_W +: DIG_W] >= 4'd9) begin
          r[i*DIG_W +: DIG_W] = '0;
        end else begin
          r[i*DIG_W +: DIG_W] = r[i*DIG_W +: DIG_W] + 4'd1;
          cy = 1'b0;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/deca_mem.sv
`timescale 1ns/1ps
module deca_mem
  import deca_pkg::*;
#(
  parameter int WORDS = MEM_WORDS
) (
  input  logic  clk,
  input  logic  we,
  input  addr_t waddr,
  input  word_t wdata,
  input  addr_t raddr,
  output word_t rdata
);
  localparam int IW = $clog2(WORDS);

  word_t cells [WORDS];

  logic          w_ok, r_ok;
  logic [IW-1:0] w_idx, r_idx;

  always_comb begin
    w_ok  = addr_index(waddr) < WORDS;
    r_ok  = addr_index(raddr) < WORDS;
    w_idx = IW'(addr_index(waddr));
    r_idx = IW'(addr_index(raddr));
  end

  always_ff @(posedge clk) begin
    if (we && w_ok) cells[w_idx] <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (r_ok) rdata = cells[r_idx];
  end
endmodule

// File: rtl/deca_alu.sv
`timescale 1ns/1ps
module deca_alu
  import deca_pkg::*;
#(
  parameter int NDIG = WORD_DIGITS
) (
  input  logic              sub,
  input  logic [NDIG*4-1:0] a,
  input  logic [NDIG*4-1:0] b,
  output logic [NDIG*4-1:0] y,
  output logic              borrow
);
  // decimal ripple chain; subtraction adds the nines' complement plus one
  logic [NDIG:0] cy;
  assign cy[0] = sub;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [3:0] bd;
    logic [4:0] s;
    assign bd = sub ? (4'd9 - b[g*4 +: 4]) : b[g*4 +: 4];
    assign s  = {1'b0, a[g*4 +: 4]} + {1'b0, bd} + {4'b0, cy[g]};
    assign cy[g+1]    = (s > 5'd9);
    assign y[g*4 +: 4] = cy[g+1] ? 4'(s - 5'd10) : s[3:0];
  end

  assign borrow = sub & ~cy[NDIG];
endmodule

// File: rtl/deca_seq.sv
`timescale 1ns/1ps
module deca_seq
  import deca_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  digit_t opcode,
  input  addr_t  operand,
  input  logic   in_valid,
  input  logic   out_ready,
  output phase_e phase
);
  phase_e nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      ST_FA:  nxt = ST_FB;
      ST_FB:  nxt = ST_FC;
      ST_FC:  nxt = ST_DEC;
      ST_DEC: begin
        case (opcode)
          OP_HLT: nxt = ST_HALT;
          OP_ADD, OP_SUB, OP_LDA, OP_STA,
          OP_BRA, OP_BRZ, OP_BRP: nxt = ST_EXEC;
          OP_IO: begin
            if (operand == IO_IN)       nxt = ST_IN;
            else if (operand == IO_OUT) nxt = ST_OUT;
            else                        nxt = ST_CHK;
          end
          default: nxt = ST_CHK;
        endcase
      end
      ST_EXEC: nxt = (opcode == OP_ADD || opcode == OP_SUB || opcode == OP_LDA)
                     ? ST_ALU : ST_CHK;
      ST_ALU:  nxt = ST_CHK;
      ST_IN:   nxt = in_valid  ? ST_CHK : ST_IN;
      ST_OUT:  nxt = out_ready ? ST_CHK : ST_OUT;
      ST_CHK:  nxt = ST_FA;
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_FA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= ST_FA;
    else     phase <= nxt;
  end

  // R7
  in_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_IN && !in_valid) |=> (phase == ST_IN));

  // R3
  fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_FB) |=> (phase == ST_FC));
endmodule

// File: rtl/deca_core.sv
`timescale 1ns/1ps
module deca_core
  import deca_pkg::*;
#(
  parameter logic [7:0] IRQ_VECTOR = 8'h90,
  parameter logic [7:0] IRQ_SAVE   = 8'h99
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              irq_req,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              halted
);
  addr_t  pc, mar;
  word_t  mdr, cir, acc;
  logic   neg, pend;
  phase_e phase;

  digit_t opc;
  addr_t  opd;
  assign opc = cir[WORD_W-1 -: DIG_W];
  assign opd = cir[ADDR_W-1:0];

  word_t rdata, alu_y;
  logic  alu_brw;
  logic  mem_we;
  addr_t mem_wa;
  word_t mem_wd;

  deca_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .opcode    (opc),
    .operand   (opd),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .phase     (phase)
  );

  deca_alu #(.NDIG(WORD_DIGITS)) u_alu (
    .sub    (opc == OP_SUB),
    .a      (acc),
    .b      (mdr),
    .y      (alu_y),
    .borrow (alu_brw)
  );

  deca_mem #(.WORDS(MEM_WORDS)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_wa),
    .wdata (mem_wd),
    .raddr (mar),
    .rdata (rdata)
  );

  // one write port shared by the load path, store and the return-address save
  always_comb begin
    mem_we = 1'b0;
    mem_wa = mar;
    mem_wd = acc;
    if (rst) begin
      mem_we = ld_en;
      mem_wa = ld_addr;
      mem_wd = ld_data;
    end else if (phase == ST_EXEC && opc == OP_STA) begin
      mem_we = 1'b1;
    end else if (phase == ST_CHK && pend) begin
      mem_we = 1'b1;
      mem_wa = IRQ_SAVE;
      mem_wd = word_t'(pc);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      mar  <= '0;
      mdr  <= '0;
      cir  <= '0;
      acc  <= '0;
      neg  <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (irq_req) pend <= 1'b1;
      unique case (phase)
        ST_FA: mar <= pc;
        ST_FB: begin
          mdr <= rdata;
          pc  <= addr_next(pc);
        end
        ST_FC:  cir <= mdr;
        ST_DEC: mar <= opd;
        ST_EXEC: begin
          case (opc)
            OP_ADD, OP_SUB, OP_LDA: mdr <= rdata;
            OP_BRA: pc <= opd;
            OP_BRZ: if (acc == '0) pc <= opd;
            OP_BRP: if (!neg)      pc <= opd;
            default: ;
          endcase
        end
        ST_ALU: begin
          if (opc == OP_LDA) begin
            acc <= mdr;
            neg <= 1'b0;
          end else begin
            acc <= alu_y;
            neg <= alu_brw;
          end
        end
        ST_IN: begin
          if (in_valid) begin
            acc <= in_data;
            neg <= 1'b0;
          end
        end
        ST_CHK: begin
          if (pend) begin
            pc   <= IRQ_VECTOR;
            pend <= irq_req;
          end
        end
        default: ;
      endcase
    end
  end

  assign in_ready  = (phase == ST_IN);
  assign out_valid = (phase == ST_OUT);
  assign out_data  = acc;
  assign halted    = (phase == ST_HALT);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  halted_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R7
  in_take_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (acc == $past(in_data)));

  // R12
  irq_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_CHK && pend) |=> (pc == IRQ_VECTOR));

  // R11
  pc_bcd_chk: assert property (@(posedge clk) disable iff (rst)
    (pc[7:4] <= 4'd9) && (pc[3:0] <= 4'd9));
endmodule

// File: tb/deca_core_bench.sv
`timescale 1ns/1ps
module deca_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [11:0] ld_data = '0;
  logic        irq_req = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [11:0] out_data;
  logic        halted;

  always #2.5 clk = ~clk;

  deca_core u_deca_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .irq_req(irq_req), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .halted(halted)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [11:0] img [100];
  logic [11:0] in_q [$];
  logic [11:0] out_got [$];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog R9: run did not end got=%0d exp=<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic logic [11:0] bcd3(input int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic logic [7:0] bcd2(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 100; i++) img[i] = 12'h000;
    in_q.delete();
  endtask

  task automatic run_prog(input bit irq_start, input bit late_en,
                          input logic [7:0] late_addr, input logic [11:0] late_data);
    bit rdy, hold_prev, bad;
    logic [11:0] hold_data;
    out_got.delete();
    rst = 1'b1; irq_req = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    for (int a = 0; a < 100; a++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = bcd2(a); ld_data = img[a];
    end
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!halted && !out_valid && !in_ready, "R1 reset outputs", {halted, out_valid, in_ready}, 0);
    rst = 1'b0;
    hold_prev = 1'b0;
    hold_data = '0;
    for (int k = 1; k <= 3000; k++) begin
      @(negedge clk);
      if (halted) break;
      irq_req = irq_start && (k == 1);
      ld_en   = late_en && (k == 3);
      ld_addr = late_addr;
      ld_data = late_data;
      if (hold_prev)
        chk(out_valid && out_data == hold_data, "R8 output held under back-pressure",
            {out_valid, out_data}, {1'b1, hold_data});
      rdy = ($urandom % 4) != 0;
      hold_prev = out_valid && !rdy;
      hold_data = out_data;
      out_ready = rdy;
      if (out_valid && rdy) out_got.push_back(out_data);
      if (in_q.size() > 0 && ($urandom % 3) != 0) begin
        in_valid = 1'b1;
        in_data  = in_q[0];
        if (in_ready) in_q.delete(0);
      end else begin
        in_valid = 1'b0;
      end
    end
    chk(halted, "R9 halt reached", halted, 1);
    irq_req = 1'b0; ld_en = 1'b0; out_ready = 1'b1; in_valid = 1'b1;
    bad = 1'b0;
    repeat (12) begin
      @(negedge clk);
      if (!halted || out_valid || in_ready) bad = 1'b1;
    end
    in_valid = 1'b0;
    chk(!bad, "R9 halt sticky, no beats", bad, 0);
  endtask

  task automatic cmp_outs(input string req, input int n,
                          input logic [11:0] e0, input logic [11:0] e1, input logic [11:0] e2);
    logic [11:0] e [3];
    e[0] = e0; e[1] = e1; e[2] = e2;
    chk(out_got.size() == n, {req, " beat count"}, out_got.size(), n);
    for (int i = 0; i < n && i < out_got.size(); i++)
      chk(out_got[i] == e[i], {req, " beat value"}, out_got[i], e[i]);
  endtask

  // R4 / R6 / R3: input a, add or subtract word 10, output, branch on sign
  task automatic arith_case(input int a, input int b, input bit sub);
    int r;
    bit ng;
    clear_img();
    img[0] = 12'h901;
    img[1] = sub ? 12'h210 : 12'h110;
    img[2] = 12'h902;
    img[3] = 12'h806;
    img[4] = 12'h511;
    img[5] = 12'h902;
    img[6] = 12'h512;
    img[7] = 12'h902;
    img[8] = 12'h000;
    img[10] = bcd3(b);
    img[11] = 12'h111;
    img[12] = 12'h222;
    in_q.push_back(bcd3(a));
    r  = sub ? (a - b + 1000) % 1000 : (a + b) % 1000;
    ng = sub && (a < b);
    run_prog(1'b0, 1'b0, 8'h00, 12'h000);
    if (ng) cmp_outs("R4 R6 arithmetic, flag and BRP", 3, bcd3(r), 12'h111, 12'h222);
    else    cmp_outs("R4 R6 arithmetic, flag and BRP", 2, bcd3(r), 12'h222, 12'h000);
    chk(in_q.size() == 0, "R7 input consumed", in_q.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);

    // directed arithmetic corners
    arith_case(500, 500, 1'b1);
    arith_case(0, 1, 1'b1);
    arith_case(999, 1, 1'b0);
    arith_case(0, 0, 1'b0);
    for (int it = 0; it < 30; it++)
      arith_case(int'($urandom % 1000), int'($urandom % 1000), bit'($urandom % 2));

    // R11 R10 R6: jump to 98, nops at 2 and 99, wrap to 00, BRZ taken on zero
    clear_img();
    img[0] = 12'h901; img[1] = 12'h710; img[2] = 12'h997; img[3] = 12'h698;
    img[98] = 12'h902; img[99] = 12'h400; img[10] = 12'h000;
    in_q.push_back(12'h005);
    in_q.push_back(12'h000);
    run_prog(1'b0, 1'b0, 8'h00, 12'h000);
    cmp_outs("R11 R10 R6 wrap, nop, BRZ", 1, 12'h005, 12'h000, 12'h000);
    chk(in_q.size() == 0, "R11 second pass through 00", in_q.size(), 0);

    // R5 R2: store then load; load port write at 21 while running is ignored
    clear_img();
    img[0] = 12'h901; img[1] = 12'h320; img[2] = 12'h521; img[3] = 12'h902;
    img[4] = 12'h520; img[5] = 12'h902; img[6] = 12'h000;
    in_q.push_back(12'h123);
    run_prog(1'b0, 1'b1, 8'h21, 12'h777);
    cmp_outs("R5 R2 store/load, late load ignored", 2, 12'h000, 12'h123, 12'h000);

    // R4: flag set by a negative subtract is cleared by ADD, so BRP is taken
    clear_img();
    img[0] = 12'h901; img[1] = 12'h210; img[2] = 12'h111; img[3] = 12'h806;
    img[4] = 12'h902; img[5] = 12'h000; img[6] = 12'h512; img[7] = 12'h902;
    img[8] = 12'h000; img[10] = 12'h999; img[11] = 12'h000; img[12] = 12'h345;
    in_q.push_back(12'h005);
    run_prog(1'b0, 1'b0, 8'h00, 12'h000);
    cmp_outs("R4 flag cleared by ADD", 1, 12'h345, 12'h000, 12'h000);

    // R12: interrupt during input; return address 01 saved at 99, handler at 90
    clear_img();
    img[0] = 12'h901; img[1] = 12'h000;
    img[90] = 12'h599; img[91] = 12'h902; img[92] = 12'h000;
    in_q.push_back(12'h007);
    run_prog(1'b1, 1'b0, 8'h00, 12'h000);
    cmp_outs("R12 interrupt save and vector", 1, 12'h001, 12'h000, 12'h000);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule